// File: doc/BRIEF.md
# Store Commit Ordering Gate

This block decides, cycle by cycle, whether a store that targets an owned data-cache line may commit now or has to wait. It sits next to a write-combining merge buffer that collects stores on their way to the external bus. Without it, a cache-hit store could finish ahead of writes still held in that buffer or still in flight outside the chip.

A two-bit mode field selects one of three ordering levels:

- **Strict** is the reset default. Every owned-line store waits for the merge buffer to empty and for the external write-buffer-empty signal to be asserted.
- **Speculative** relaxes ordering for the uncacheable and write-combining memory types.
- **Relaxed** turns all ordering off.

The external empty signal is active low. It is brought in through a synchronizer.

Software, or a surrounding feature-register file, loads the mode through a write-enable port. The cache, the memory-type lookup, the bus unit and the merging datapath are outside this block. They reach it only as inputs: the store's memory type, the line state, the buffer occupancy and the memory type of the buffered writes. Whenever a stall is caused by buffer contents, the block also asks the merge buffer to drain.

Top module: `wr_order_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the mode field to 00 (strict) and presets the synchronized empty signal to its negated value 1. A store to an owned line therefore stalls right after reset.
- R2: When cfg_we is 1 at a rising edge, cfg_mode is loaded. Bit 1 is the global-disable bit and bit 0 is the speculative-disable bit. The new level governs stall from the following cycle onward.
- R3: With bit 1 set (mode 10 or 11), st_stall and mb_drain_req stay 0 for every input pattern. Bit 0 and the empty input have no effect in this level.
- R4: In mode 00, a valid store to a line in state E or M stalls if mb_count is non-zero or if the synchronized empty signal is 1 (negated).
- R5: In mode 01, a store whose type is UC (code 0) or WC (code 1) never stalls. For a store of any other type, the block stalls if the synchronized empty signal is negated. It also stalls if mb_count is non-zero and mb_mtype is neither UC nor WC.
- R6: Line-state encoding is I=0, S=1, E=2, M=3. Stores to I or S lines never stall.
- R7: ext_empty_n reaches the decision through a two-flop synchronizer. A change driven between edges influences st_stall after exactly two rising edges.
- R8: commit_ok is 1 exactly when st_valid is 1 and st_stall is 0. Both follow the current store inputs in the same cycle.
- R9: mb_drain_req is 1 exactly when a stalled store is being held by merge-buffer contents under the active level, as defined in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode field write enable |
| cfg_mode | input | 2 | Mode write data: bit 1 global disable, bit 0 speculative disable |
| ext_empty_n | input | 1 | External write-buffer-empty, active low, asynchronous |
| st_valid | input | 1 | A store is requesting commit this cycle |
| st_mtype | input | 3 | Memory type of the store (0 UC, 1 WC, others cacheable) |
| st_state | input | 2 | Line state of the store target (I=0, S=1, E=2, M=3) |
| mb_count | input | 4 | Number of writes held in the merge buffer |
| mb_mtype | input | 3 | Memory type of the buffered writes |
| st_stall | output | 1 | Store must wait this cycle |
| commit_ok | output | 1 | Store may commit this cycle |
| mb_drain_req | output | 1 | Request to flush the merge buffer |

## Verification
A wrong stored mode shows up at the ports on the first owned-line store after the bad write. That store stalls when it should commit, or commits when it should stall, and so does every later store whose inputs separate the two levels. A synchronizer that holds the wrong value, or delays by the wrong number of stages, moves the stall release by one or more cycles relative to the empty input, so an edge-exact comparison catches it within two cycles of any change. Because the decision is combinational from these two pieces of state, each mismatch becomes visible in the cycle the store is presented.

// File: rtl/wo_pkg.sv
package wo_pkg;
  localparam int MT_W = 3;
  typedef logic [MT_W-1:0] mtype_t;

  localparam mtype_t MT_UC = 3'd0;
  localparam mtype_t MT_WC = 3'd1;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    ORD_STRICT  = 2'd0,
    ORD_SPEC    = 2'd1,
    ORD_RELAXED = 2'd2
  } ord_lvl_e;

  // Uncacheable and write-combining traffic is exempt in speculative level
  function automatic logic mt_exempt(input mtype_t t);
    return (t == MT_UC) || (t == MT_WC);
  endfunction
endpackage

// File: rtl/wo_sync.sv
module wo_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wo_mode_reg.sv
module wo_mode_reg
  import wo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] wdata,
  output logic [1:0] bits_q,
  output ord_lvl_e   level
);
  always_ff @(posedge clk) begin
    if (rst)     bits_q <= 2'b00;
    else if (we) bits_q <= wdata;
  end

  // Global disable outranks speculative disable
  always_comb begin
    if (bits_q[1])      level = ORD_RELAXED;
    else if (bits_q[0]) level = ORD_SPEC;
    else                level = ORD_STRICT;
  end
endmodule

// File: rtl/wo_gate.sv
module wo_gate
  import wo_pkg::*;
(
  input  ord_lvl_e   level,
  input  logic       ext_busy,
  input  logic       st_valid,
  input  mtype_t     st_mtype,
  input  logic [1:0] st_state,
  input  logic       mb_busy,
  input  mtype_t     mb_mtype,
  output logic       stall,
  output logic       drain
);
  logic owned;
  logic buf_term;
  logic ext_term;
  logic st_free;

  always_comb begin
    owned   = st_valid && ((st_state == LS_E) || (st_state == LS_M));
    st_free = mt_exempt(st_mtype);
    unique case (level)
      ORD_RELAXED: begin
        buf_term = 1'b0;
        ext_term = 1'b0;
      end
      ORD_SPEC: begin
        buf_term = !st_free && mb_busy && !mt_exempt(mb_mtype);
        ext_term = !st_free && ext_busy;
      end
      default: begin
        buf_term = mb_busy;
        ext_term = ext_busy;
      end
    endcase
    stall = owned && (buf_term || ext_term);
    drain = owned && buf_term;
  end
endmodule

// File: rtl/wr_order_ctrl.sv
module wr_order_ctrl
  import wo_pkg::*;
#(
  parameter int MB_DEPTH    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(MB_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic             ext_empty_n,
  input  logic             st_valid,
  input  logic [MT_W-1:0]  st_mtype,
  input  logic [1:0]       st_state,
  input  logic [CNT_W-1:0] mb_count,
  input  logic [MT_W-1:0]  mb_mtype,
  output logic             st_stall,
  output logic             commit_ok,
  output logic             mb_drain_req
);
  logic [1:0] mode_bits;
  ord_lvl_e   level;
  logic       ext_busy;
  logic       mb_busy;

  wo_mode_reg u_mode (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_mode),
    .bits_q (mode_bits),
    .level  (level)
  );

  // Reset value 1: treat the outside as busy until proven empty
  wo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_empty_n),
    .q   (ext_busy)
  );

  assign mb_busy = (mb_count != '0);

  wo_gate u_gate (
    .level    (level),
    .ext_busy (ext_busy),
    .st_valid (st_valid),
    .st_mtype (st_mtype),
    .st_state (st_state),
    .mb_busy  (mb_busy),
    .mb_mtype (mb_mtype),
    .stall    (st_stall),
    .drain    (mb_drain_req)
  );

  assign commit_ok = st_valid && !st_stall;
endmodule

// File: rtl/wr_order_ctrl_chk.sv
module wr_order_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [1:0]       cfg_mode,
  input logic [1:0]       mode_bits,
  input logic             ext_empty_n,
  input logic             ext_busy,
  input logic             st_valid,
  input logic [1:0]       st_state,
  input logic [CNT_W-1:0] mb_count,
  input logic             st_stall,
  input logic             commit_ok,
  input logic             mb_drain_req
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_strict: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_bits == 2'b00));

  a_r2_cfg_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_we)) |-> (mode_bits == $past(cfg_mode)));

  a_r3_relaxed_free: assert property (@(posedge clk) disable iff (rst)
    mode_bits[1] |-> (!st_stall && !mb_drain_req));

  a_r4_strict_hold: assert property (@(posedge clk) disable iff (rst)
    ((mode_bits == 2'b00) && st_valid && st_state[1] &&
     ((mb_count != '0) || ext_busy)) |-> st_stall);

  a_r6_unowned_free: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_state[1]) |-> !st_stall);

  a_r7_sync_delay: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (ext_busy == $past(ext_empty_n, 2)));

  a_r8_commit_clean: assert property (@(posedge clk) disable iff (rst)
    commit_ok |-> (st_valid && !st_stall));

  a_r9_drain_cause: assert property (@(posedge clk) disable iff (rst)
    mb_drain_req |-> (st_stall && (mb_count != '0)));
endmodule

bind wr_order_ctrl wr_order_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .cfg_mode     (cfg_mode),
  .mode_bits    (mode_bits),
  .ext_empty_n  (ext_empty_n),
  .ext_busy     (ext_busy),
  .st_valid     (st_valid),
  .st_state     (st_state),
  .mb_count     (mb_count),
  .st_stall     (st_stall),
  .commit_ok    (commit_ok),
  .mb_drain_req (mb_drain_req)
);

// File: tb/wr_order_ctrl_test.sv
module wr_order_ctrl_test;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_mode = 2'b00;
  logic             ext_empty_n = 1'b0;
  logic             st_valid = 1'b1;
  logic [2:0]       st_mtype = 3'd6;
  logic [1:0]       st_state = 2'd3;
  logic [CNT_W-1:0] mb_count = '0;
  logic [2:0]       mb_mtype = 3'd6;
  logic             st_stall, commit_ok, mb_drain_req;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference state
  int m_mode = 0;
  int m_hist[$];

  always #4 clk = ~clk;

  wr_order_ctrl uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .ext_empty_n(ext_empty_n), .st_valid(st_valid), .st_mtype(st_mtype),
    .st_state(st_state), .mb_count(mb_count), .mb_mtype(mb_mtype),
    .st_stall(st_stall), .commit_ok(commit_ok), .mb_drain_req(mb_drain_req)
  );

  initial begin
    m_hist = '{1, 1};
  end

  // reference: mode register and a 2-deep history of the empty input
  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0;
      m_hist = '{1, 1};
    end else begin
      if (cfg_we) m_mode = int'(cfg_mode);
      m_hist.push_back(int'(ext_empty_n));
      void'(m_hist.pop_front());
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    bit owned, exempt_st, exempt_mb, busy_ext, busy_buf, e_stall, e_drain;
    string tag;
    owned     = st_valid && (st_state >= 2);
    exempt_st = (st_mtype < 3'd2);
    exempt_mb = (mb_mtype < 3'd2);
    busy_ext  = (m_hist[0] == 1);
    busy_buf  = (mb_count != 0);
    e_stall = 0;
    e_drain = 0;
    if (!owned) begin
      tag = "R6";
    end else if (m_mode >= 2) begin
      tag = "R3";
    end else if (m_mode == 1) begin
      tag = "R5";
      if (!exempt_st) begin
        e_drain = busy_buf && !exempt_mb;
        e_stall = busy_ext || e_drain;
      end
    end else begin
      tag = "R4";
      e_drain = busy_buf;
      e_stall = busy_ext || busy_buf;
    end
    check({tag, " stall"}, st_stall, e_stall);
    check("R9 drain", mb_drain_req, e_drain);
    check("R8 commit", commit_ok, st_valid && !e_stall);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 stall after reset", st_stall, 1'b1);
    check("R1 commit after reset", commit_ok, 1'b0);
    @(negedge clk); #1;
    check("R7 one edge not enough", st_stall, 1'b1);
    @(negedge clk); #1;
    check("R7 released after two edges", st_stall, 1'b0);
    check("R8 commit on release", commit_ok, 1'b1);

    // R2: relaxed level takes effect one cycle after the write
    ext_empty_n = 1'b1;
    mb_count = 4'd3;
    cfg_we = 1'b1;
    cfg_mode = 2'b10;
    #1;
    check("R2 old level still in force", st_stall, 1'b1);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R2 new level applied", st_stall, 1'b0);
    check("R3 no drain relaxed", mb_drain_req, 1'b0);

    // R5: speculative level exempts a WC store
    cfg_we = 1'b1;
    cfg_mode = 2'b01;
    @(negedge clk);
    cfg_we = 1'b0;
    st_mtype = 3'd1;
    #1;
    check("R5 WC store exempt", st_stall, 1'b0);
    st_mtype = 3'd6;
    mb_mtype = 3'd1;
    ext_empty_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R5 WC buffer ignored", st_stall, 1'b0);
    check("R9 no drain for WC buffer", mb_drain_req, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cfg_we      = ($urandom_range(0, 15) == 0);
      cfg_mode    = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) ext_empty_n = ~ext_empty_n;
      st_valid    = ($urandom_range(0, 7) != 0);
      st_mtype    = 3'($urandom_range(0, 7));
      st_state    = 2'($urandom_range(0, 3));
      mb_count    = ($urandom_range(0, 1) == 0) ? '0 : CNT_W'($urandom_range(1, 8));
      mb_mtype    = 3'($urandom_range(0, 7));
      #1;
      compare_model();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule